// File: doc/BRIEF.md
# Timed pulse program sequencer

This block is one timing core that plays a stored pulse program onto a single output flag. Each word of its instruction memory holds an opcode, an output level and a duration counted in clock cycles. From the first word onward the core drives the flag at each word's level for that many cycles and then moves to the next word. Intervals follow each other with no gap cycles, and the program ends at a STOP word. A program that has no STOP word runs in a loop from the last address back to address 0 until it is halted.

A host loads and inspects the memory through a simple request port. The port only works while the core is idle. Any request made while the core runs gets a refusal and has no effect. A start pulse launches the program from address 0. A halt pulse forces the core back to idle within one cycle. Durations shorter than the hardware minimum are stretched to that minimum, and a sticky error flag records that this happened.

The controller has four named states. IDLE waits for start. PRIME issues the read of word 0. LOAD decodes the first word. RUN counts an interval down while the next word is read ahead of time. The transitions are:
- start: IDLE to PRIME.
- prime_done: PRIME to LOAD.
- load_continue: LOAD to RUN.
- load_stop: LOAD to IDLE.
- interval_next: RUN to RUN, when the count ends on a CONTINUE word.
- interval_stop: RUN to IDLE, when the count ends on a STOP word.
- halt: any state to IDLE.

Top module: `pulse_seq_core`

## Requirements
- R1: After reset, flag_o, running_o, clamp_err_o, host_ack_o and host_nak_o are all 0.
- R2: When start_i is high in a cycle in which the core is idle and halt_i is low, running_o is 1 after the next edge. The first word's level appears on flag_o after the third edge.
- R3: A memory word is {op at bit DUR_W+1, level at bit DUR_W, duration in bits DUR_W-1:0}, where op 0 means CONTINUE and op 1 means STOP. For a CONTINUE word, flag_o holds the level for exactly the duration in cycles. The next word's interval follows directly, with no gap cycle.
- R4: A CONTINUE duration below MIN_LEN (default 18) is held for MIN_LEN cycles. Such a duration also sets clamp_err_o, which stays set until rst_n.
- R5: Once the last interval before a STOP word ends, flag_o and running_o are 0 from the next cycle on. The next start runs from address 0 again. A STOP word at address 0 ends the run with flag_o never set.
- R6: A program without a STOP word wraps from the last address to address 0 and repeats with no gap.
- R7: When halt_i is high, flag_o and running_o are 0 after the next edge, and the next start begins at address 0. halt_i wins over a start_i in the same cycle.
- R8: start_i has no effect while the core is running.
- R9: While idle, a host request (host_req_i) is answered with host_ack_o one cycle later. A write (host_we_i=1) stores host_wdata_i at host_addr_i. For a read, host_rdata_o carries the word in the acknowledge cycle. host_ack_o and host_nak_o are never high together.
- R10: A host request made while the core runs is answered with host_nak_o one cycle later and does not change the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse |
| halt_i | input | 1 | Synchronous halt, returns the core to idle |
| host_req_i | input | 1 | Host access request |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | ADDR_W | Host word address |
| host_wdata_i | input | DUR_W+2 | Host write word |
| host_ack_o | output | 1 | Request accepted (one cycle after request) |
| host_nak_o | output | 1 | Request refused because the core was running |
| host_rdata_o | output | DUR_W+2 | Read data, valid with host_ack_o on a read |
| running_o | output | 1 | Core is executing |
| flag_o | output | 1 | Pulse output |
| clamp_err_o | output | 1 | Sticky short-duration flag |

## Verification
Two situations are hard to reach from the ports. One is the program-counter wrap with no STOP word. The other is a host write that lands in the middle of a run. The bench fills a reduced eight-word memory entirely with CONTINUE words, follows the flag through two full passes and one partial pass against a cycle model, and then halts. It also issues a write and a read while an interval is still counting down. It then reads the word back after the STOP, which shows the refused write left the memory unchanged.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

    localparam int DEF_DUR_W   = 29;
    localparam int DEF_MIN_LEN = 18;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRIME = 2'd1,
        ST_LOAD  = 2'd2,
        ST_RUN   = 2'd3
    } seq_state_t;

    localparam logic OP_CONT = 1'b0;
    localparam logic OP_STOP = 1'b1;

endpackage

// File: rtl/pseq_imem.sv
module pseq_imem #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 31,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
        rdata <= store[raddr];
    end

endmodule

// File: rtl/pseq_host_gate.sv
module pseq_host_gate #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle_i,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    output logic              rd_sel_o,
    output logic              ack_o,
    output logic              nak_o
);

    logic granted;

    assign granted     = req_i && idle_i;
    assign mem_we_o    = granted && we_i;
    assign rd_sel_o    = granted && !we_i;
    assign mem_addr_o  = addr_i;
    assign mem_wdata_o = wdata_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_o <= 1'b0;
            nak_o <= 1'b0;
        end else begin
            ack_o <= granted;
            nak_o <= req_i && !idle_i;
        end
    end

endmodule

// File: rtl/pseq_ctrl.sv
module pseq_ctrl
    import pseq_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int DUR_W   = DEF_DUR_W,
    parameter int MIN_LEN = DEF_MIN_LEN,
    localparam int WORD_W = DUR_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              halt_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic              idle_o,
    output logic              cnt_zero_o,
    output logic              flag_o,
    output logic              clamp_err_o
);

    localparam logic [DUR_W-1:0] MIN_DUR   = DUR_W'(MIN_LEN);
    localparam logic [DUR_W-1:0] MIN_DUR_M1 = DUR_W'(MIN_LEN - 1);

    seq_state_t        st, st_nxt;
    logic [DUR_W-1:0]  remain;
    logic              w_stop, w_level, w_short;
    logic [DUR_W-1:0]  w_dur, w_eff_m1;
    logic              at_boundary, do_load, do_finish;

    assign w_stop   = (word_i[WORD_W-1] == OP_STOP);
    assign w_level  = word_i[DUR_W];
    assign w_dur    = word_i[DUR_W-1:0];
    assign w_short  = (w_dur < MIN_DUR);
    assign w_eff_m1 = w_short ? MIN_DUR_M1 : (w_dur - 1'b1);

    assign cnt_zero_o  = (remain == '0);
    assign at_boundary = (st == ST_LOAD) || ((st == ST_RUN) && cnt_zero_o);
    assign do_load     = !halt_i && at_boundary && !w_stop;
    assign do_finish   = !halt_i && at_boundary && w_stop;
    assign idle_o      = (st == ST_IDLE);

    // next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:  if (start_i) st_nxt = ST_PRIME;
            ST_PRIME: st_nxt = ST_LOAD;
            ST_LOAD:  st_nxt = w_stop ? ST_IDLE : ST_RUN;
            ST_RUN:   if (cnt_zero_o && w_stop) st_nxt = ST_IDLE;
        endcase
        if (halt_i) begin
            st_nxt = ST_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_o        <= '0;
            remain      <= '0;
            flag_o      <= 1'b0;
            clamp_err_o <= 1'b0;
        end else if (halt_i) begin
            pc_o   <= '0;
            remain <= '0;
            flag_o <= 1'b0;
        end else if (do_load) begin
            flag_o <= w_level;
            remain <= w_eff_m1;
            pc_o   <= pc_o + 1'b1;
            if (w_short) begin
                clamp_err_o <= 1'b1;
            end
        end else if (do_finish) begin
            flag_o <= 1'b0;
            remain <= '0;
            pc_o   <= '0;
        end else if (st == ST_RUN) begin
            remain <= remain - 1'b1;
        end
    end

endmodule

// File: rtl/pulse_seq_core.sv
module pulse_seq_core
    import pseq_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int DUR_W   = DEF_DUR_W,
    parameter int MIN_LEN = DEF_MIN_LEN,
    localparam int WORD_W = DUR_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              halt_i,
    input  logic              host_req_i,
    input  logic              host_we_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [WORD_W-1:0] host_wdata_i,
    output logic              host_ack_o,
    output logic              host_nak_o,
    output logic [WORD_W-1:0] host_rdata_o,
    output logic              running_o,
    output logic              flag_o,
    output logic              clamp_err_o
);

    logic              ctl_idle;
    logic              ctl_cnt_zero;
    logic [ADDR_W-1:0] ctl_pc;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [WORD_W-1:0] mem_wdata;
    logic              host_rd_sel;
    logic [ADDR_W-1:0] mem_raddr;
    logic [WORD_W-1:0] mem_rdata;

    assign mem_raddr    = host_rd_sel ? mem_addr : ctl_pc;
    assign host_rdata_o = mem_rdata;
    assign running_o    = !ctl_idle;

    pseq_imem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_imem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_addr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    pseq_host_gate #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .idle_i      (ctl_idle),
        .req_i       (host_req_i),
        .we_i        (host_we_i),
        .addr_i      (host_addr_i),
        .wdata_i     (host_wdata_i),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .rd_sel_o    (host_rd_sel),
        .ack_o       (host_ack_o),
        .nak_o       (host_nak_o)
    );

    pseq_ctrl #(.ADDR_W(ADDR_W), .DUR_W(DUR_W), .MIN_LEN(MIN_LEN)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .halt_i      (halt_i),
        .word_i      (mem_rdata),
        .pc_o        (ctl_pc),
        .idle_o      (ctl_idle),
        .cnt_zero_o  (ctl_cnt_zero),
        .flag_o      (flag_o),
        .clamp_err_o (clamp_err_o)
    );

endmodule

// File: rtl/pulse_seq_core_chk.sv
module pulse_seq_core_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic halt_i,
    input logic running_o,
    input logic flag_o,
    input logic clamp_err_o,
    input logic host_ack_o,
    input logic host_nak_o,
    input logic mem_we,
    input logic cnt_zero
);

    assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !halt_i && !running_o) |=> running_o);

    assert_level_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && !cnt_zero && !halt_i) |=> $stable(flag_o));

    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_err_o |=> clamp_err_o);

    assert_idle_flag_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !running_o |-> !flag_o);

    assert_halt_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> (!running_o && !flag_o));

    assert_resp_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_ack_o && host_nak_o));

    assert_nak_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_nak_o |-> $past(running_o));

    assert_no_write_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !running_o);

endmodule

bind pulse_seq_core pulse_seq_core_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .halt_i      (halt_i),
    .running_o   (running_o),
    .flag_o      (flag_o),
    .clamp_err_o (clamp_err_o),
    .host_ack_o  (host_ack_o),
    .host_nak_o  (host_nak_o),
    .mem_we      (mem_we),
    .cnt_zero    (ctl_cnt_zero)
);

// File: tb/pulse_seq_core_bench.sv
`timescale 1ns/1ps
module pulse_seq_core_bench;

    localparam int ADDR_W = 3;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DUR_W  = 29;
    localparam int WORD_W = DUR_W + 2;
    localparam int MINL   = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, halt_i = 1'b0;
    logic host_req_i = 1'b0, host_we_i = 1'b0;
    logic [ADDR_W-1:0] host_addr_i = '0;
    logic [WORD_W-1:0] host_wdata_i = '0;
    logic host_ack_o, host_nak_o, running_o, flag_o, clamp_err_o;
    logic [WORD_W-1:0] host_rdata_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    bit p_op [DEPTH];
    bit p_lvl [DEPTH];
    int p_dur [DEPTH];

    always #2 clk = ~clk;

    pulse_seq_core #(.ADDR_W(ADDR_W), .DUR_W(DUR_W), .MIN_LEN(MINL)) u_pulse_seq_core (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .halt_i(halt_i),
        .host_req_i(host_req_i), .host_we_i(host_we_i), .host_addr_i(host_addr_i),
        .host_wdata_i(host_wdata_i), .host_ack_o(host_ack_o), .host_nak_o(host_nak_o),
        .host_rdata_o(host_rdata_o), .running_o(running_o), .flag_o(flag_o),
        .clamp_err_o(clamp_err_o)
    );

    function automatic logic [WORD_W-1:0] mk(input bit op, input bit lvl, input int dur);
        return {op, lvl, dur[DUR_W-1:0]};
    endfunction

    function automatic int eff(input int d);
        return (d < MINL) ? MINL : d;
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic host_op(input bit we, input int addr, input logic [WORD_W-1:0] wd,
                           output bit ack, output bit nak, output logic [WORD_W-1:0] rd);
        host_req_i = 1'b1; host_we_i = we; host_addr_i = addr[ADDR_W-1:0]; host_wdata_i = wd;
        @(negedge clk);
        ack = host_ack_o; nak = host_nak_o; rd = host_rdata_o;
        host_req_i = 1'b0; host_we_i = 1'b0;
    endtask

    task automatic load_word(input int idx, input bit op, input bit lvl, input int dur);
        bit a, n; logic [WORD_W-1:0] r;
        p_op[idx] = op; p_lvl[idx] = lvl; p_dur[idx] = dur;
        host_op(1'b1, idx, mk(op, lvl, dur), a, n, r);
        chk("R9", "write ack", a, 1);
    endtask

    task automatic load_basic();
        load_word(0, 0, 1, 20);
        load_word(1, 0, 0, 25);
        load_word(2, 0, 1, 18);
        load_word(3, 1, 0, 0);
    endtask

    // start, then compare every cycle against a cycle model of the program
    task automatic run_trace(input string req, input int nsamp, input int poke_at, input int halt_at);
        int m_pc = 0; int m_rem = 0; bit m_lvl = 0; bit m_done = 0; bit halted = 0;
        int errs = 0; bit er, ef;
        start_i = 1'b1;
        for (int k = 1; k <= nsamp; k++) begin
            @(negedge clk);
            if (halted) begin
                er = 0; ef = 0;
            end else if (k <= 2) begin
                er = 1; ef = 0;
            end else begin
                if (!m_done && m_rem == 0) begin
                    if (p_op[m_pc]) m_done = 1;
                    else begin
                        m_rem = eff(p_dur[m_pc]); m_lvl = p_lvl[m_pc];
                        m_pc = (m_pc + 1) % DEPTH;
                    end
                end
                if (m_done) begin er = 0; ef = 0; end
                else begin er = 1; ef = m_lvl; m_rem--; end
            end
            if (running_o !== er || flag_o !== ef) begin
                if (errs == 0)
                    $display("FAIL %s trace cycle %0d: actual run=%0b flag=%0b expected run=%0b flag=%0b",
                             req, k, running_o, flag_o, er, ef);
                errs++;
            end
            start_i = (k == poke_at);
            halt_i  = (k == halt_at);
            if (k == halt_at) halted = 1;
        end
        start_i = 1'b0; halt_i = 1'b0;
        total++;
        if (errs != 0) bad++;
    endtask

    task automatic t_reset();
        chk("R1", "flag", flag_o, 0);
        chk("R1", "running", running_o, 0);
        chk("R1", "clamp_err", clamp_err_o, 0);
        chk("R1", "ack/nak", {host_ack_o, host_nak_o}, 0);
    endtask

    task automatic t_host_rw();
        bit a, n; logic [WORD_W-1:0] r;
        load_word(5, 0, 1, 123);
        load_word(6, 1, 0, 7);
        host_op(1'b0, 5, '0, a, n, r);
        chk("R9", "read ack", a, 1);
        chk("R9", "read data 5", r, mk(0, 1, 123));
        host_op(1'b0, 6, '0, a, n, r);
        chk("R9", "read data 6", r, mk(1, 0, 7));
    endtask

    task automatic t_basic();
        load_basic();
        run_trace("R2 R3 R5 basic", 68, 0, 0);
        chk("R4", "no clamp on legal durations", clamp_err_o, 0);
        run_trace("R5 restart from 0", 68, 0, 0);
    endtask

    task automatic t_stop_first();
        load_word(0, 1, 1, 40);
        run_trace("R5 stop at word 0", 6, 0, 0);
    endtask

    task automatic t_start_ignored();
        load_basic();
        run_trace("R8 start while running", 68, 20, 0);
    endtask

    task automatic t_halt();
        load_basic();
        run_trace("R7 halt mid interval", 34, 0, 30);
        run_trace("R7 restart after halt", 68, 0, 0);
        start_i = 1'b1; halt_i = 1'b1;
        @(negedge clk);
        chk("R7", "halt beats start", running_o, 0);
        start_i = 1'b0; halt_i = 1'b0;
        @(negedge clk);
        chk("R7", "still idle", running_o, 0);
    endtask

    task automatic t_wrap();
        for (int i = 0; i < DEPTH; i++) load_word(i, 0, i[0], 18 + i);
        run_trace("R6 wrap without stop", 365, 0, 360);
    endtask

    task automatic t_clamp();
        load_word(0, 0, 1, 5);
        load_word(1, 0, 0, 30);
        load_word(2, 1, 0, 0);
        chk("R4", "err clear before", clamp_err_o, 0);
        run_trace("R4 short duration stretched", 53, 0, 0);
        chk("R4", "err set", clamp_err_o, 1);
        load_basic();
        run_trace("R4 clean program", 68, 0, 0);
        chk("R4", "err sticky", clamp_err_o, 1);
    endtask

    task automatic t_busy_host();
        bit a, n; logic [WORD_W-1:0] r;
        load_basic();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (6) @(negedge clk);
        host_op(1'b1, 1, mk(0, 1, 99), a, n, r);
        chk("R10", "write nak", n, 1);
        chk("R10", "write no ack", a, 0);
        host_op(1'b0, 2, '0, a, n, r);
        chk("R10", "read nak", n, 1);
        for (int i = 0; i < 200 && running_o; i++) @(negedge clk);
        chk("R5", "run ended", running_o, 0);
        host_op(1'b0, 1, '0, a, n, r);
        chk("R10", "word unchanged", r, mk(0, 0, 25));
        chk("R9", "idle read ack", a, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R2 watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_host_rw();
        t_basic();
        t_stop_first();
        t_start_ignored();
        t_halt();
        t_wrap();
        t_clamp();
        t_busy_host();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule